// File: doc/BRIEF.md
# Dual-Phase Switching Clock Synchronizer

This block produces the switching timing for two buck regulator channels. The timing comes either from a base oscillator or from an external clock on a sync pin. The block divides the selected tick stream by two to form a switching clock. Channel 1 receives a one-cycle start strobe when that clock rises. Channel 2 receives its strobe when the clock falls, so the two channels run half a period apart.

The state of the sync pin sets the operating mode. A pin held low selects a clock output that copies the switching clock. A pin held high selects a clock output at twice the switching frequency, delayed by a quarter of a switching period, so that a second controller can interleave as four phases. A pin that toggles makes the block a slave: each rising edge of the pin is one source tick, and the clock output copies the switching clock.

The pin is asynchronous. It passes through a two-flop synchronizer before any use. The block assumes the mode is external while pin edges keep arriving. It returns to reading the pin as a static level once a set number of oscillator ticks pass with no edge.

All inputs and outputs are plain single-cycle control signals. No port carries data, so no port has valid/ready back-pressure.

Top module: `clksync_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sw_clk`, `clk_out`, `ch1_start` and `ch2_start` are all 0. The first start strobe after reset is `ch1_start`.
- R2: `sw_clk` inverts exactly once per source tick and holds its value between ticks, so it runs at half the source tick rate.
- R3: `ch1_start` is a one-cycle pulse in the same cycle in which `sw_clk` goes from 0 to 1, and at no other time.
- R4: `ch2_start` is a one-cycle pulse in the same cycle in which `sw_clk` goes from 1 to 0, and at no other time. `ch2_start` and `ch1_start` are never high together.
- R5: With the sync pin held low, the source tick is `osc_tick` and `clk_out` equals `sw_clk` in every cycle.
- R6: With the sync pin held high, the source tick is `osc_tick`. `clk_out` goes to 0 in the cycle after each source tick. It goes to 1 floor(P/2) cycles after that tick, where P is the previous tick interval in clock cycles. It therefore has one full period per tick interval.
- R7: After a sync pin edge has been seen, the block is in external mode. Each synchronized rising edge of the pin is a source tick, `osc_tick` has no effect on `sw_clk` or the strobes, and `clk_out` equals `sw_clk`.
- R8: In external mode, after TIMEOUT_TICKS `osc_tick` pulses with no sync pin edge, the block returns to static mode. Those TIMEOUT_TICKS pulses are ignored, and the next `osc_tick` toggles `sw_clk` again.
- R9: Assume the sync pin rises before clock edge k. With that edge counted as the first, the resulting `sw_clk` toggle and start strobe appear after the third clock edge. This delay is two synchronizer stages plus one edge-detect stage. The pin therefore must stay at each level for at least two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per base oscillator period |
| sync_pin | input | 1 | Asynchronous sync pin: static low, static high, or external clock |
| sw_clk | output | 1 | Switching clock, half the source tick rate |
| ch1_start | output | 1 | Channel 1 cycle-start strobe |
| ch2_start | output | 1 | Channel 2 cycle-start strobe |
| clk_out | output | 1 | Clock output for downstream controllers |

## Verification
The hardest condition to reach from the ports is the return from external mode to static mode. It needs a run of pin edges to enter slave operation, then a pin that goes quiet while oscillator ticks continue. The bench first drives several sync pin periods with oscillator pulses placed in both pin phases, which shows the pulses are ignored. It then holds the pin low and counts oscillator ticks. It checks that exactly the timeout number of ticks leaves `sw_clk` unchanged, and that the next tick toggles it. The quarter-period output is checked with both an even and an odd tick interval, so the floor of the half interval is exercised.

// File: rtl/clksync_pkg.sv
package clksync_pkg;
  typedef enum logic [1:0] {
    SM_LOW  = 2'd0,
    SM_HIGH = 2'd1,
    SM_EXT  = 2'd2
  } sync_mode_t;
endpackage

// File: rtl/clksync_mode_det.sv
module clksync_mode_det
  import clksync_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       sync_pin,
  output logic       sync_rise,
  output sync_mode_t mode
);
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(TIMEOUT_TICKS - 1);

  // Two-flop synchronizer plus one history flop. These flops have no reset,
  // so a pin held at a level during reset does not show up as an edge.
  logic [2:0] pin_pipe;
  always_ff @(posedge clk) begin
    pin_pipe <= {pin_pipe[1:0], sync_pin};
  end

  logic pin_q, pin_edge;
  assign pin_q     = pin_pipe[1];
  assign pin_edge  = pin_pipe[1] ^ pin_pipe[2];
  assign sync_rise = pin_pipe[1] & ~pin_pipe[2];

  logic          ext_q;
  logic [CW-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q     <= 1'b0;
      quiet_cnt <= '0;
    end else if (pin_edge) begin
      ext_q     <= 1'b1;
      quiet_cnt <= '0;
    end else if (ext_q && osc_tick) begin
      if (quiet_cnt == LAST_CNT) begin
        ext_q     <= 1'b0;
        quiet_cnt <= '0;
      end else begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (ext_q)      mode = SM_EXT;
    else if (pin_q) mode = SM_HIGH;
    else            mode = SM_LOW;
  end
endmodule

// File: rtl/clksync_divider.sv
module clksync_divider (
  input  logic clk,
  input  logic rst_n,
  input  logic src_tick,
  output logic sw_clk,
  output logic ch1_start,
  output logic ch2_start
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_clk    <= 1'b0;
      ch1_start <= 1'b0;
      ch2_start <= 1'b0;
    end else begin
      sw_clk    <= sw_clk ^ src_tick;
      ch1_start <= src_tick & ~sw_clk;
      ch2_start <= src_tick & sw_clk;
    end
  end
endmodule

// File: rtl/clksync_quad.sv
module clksync_quad #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_tick,
  output logic quad_clk
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] icnt, period_q;
  logic [CNT_W-1:0] half, icnt_inc;

  assign half     = period_q >> 1;
  assign icnt_inc = icnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icnt     <= '0;
      period_q <= '0;
      quad_clk <= 1'b0;
    end else if (src_tick) begin
      period_q <= icnt_inc;
      icnt     <= '0;
      quad_clk <= 1'b0;
    end else begin
      if (icnt != CNT_MAX) icnt <= icnt_inc;
      if ((half != '0) && (icnt_inc == half)) quad_clk <= 1'b1;
    end
  end
endmodule

// File: rtl/clksync_top.sv
module clksync_top
  import clksync_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 4,
  parameter int CNT_W         = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic sync_pin,
  output logic sw_clk,
  output logic ch1_start,
  output logic ch2_start,
  output logic clk_out
);
  sync_mode_t mode;
  logic       sync_rise, src_tick, quad_clk;

  clksync_mode_det #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_det (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sync_pin(sync_pin),
    .sync_rise(sync_rise), .mode(mode)
  );

  assign src_tick = (mode == SM_EXT) ? sync_rise : osc_tick;

  clksync_divider u_div (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .sw_clk(sw_clk), .ch1_start(ch1_start), .ch2_start(ch2_start)
  );

  clksync_quad #(.CNT_W(CNT_W)) u_quad (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .quad_clk(quad_clk)
  );

  assign clk_out = (mode == SM_HIGH) ? quad_clk : sw_clk;
endmodule

// File: rtl/clksync_chk.sv
module clksync_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_clk,
  input logic ch1_start,
  input logic ch2_start,
  input logic clk_out
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch1_start && ch2_start)); // R4
  AST_CH1_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_start |-> $rose(sw_clk)); // R3
  AST_CH2_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ch2_start |-> $fell(sw_clk)); // R4
  AST_SW_MOVES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_clk) |-> (ch1_start || ch2_start)); // R2
  AST_CKO_LOW_AT_CH2: assert property (@(posedge clk) disable iff (!rst_n)
    ch2_start |-> !clk_out); // R6
endmodule

bind clksync_top clksync_chk u_chk (.*);

// File: tb/tb_clksync_top.sv
`timescale 1ns/1ps
module tb_clksync_top;
  localparam int TO = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic sync_pin = 1'b0;
  logic sw_clk, ch1_start, ch2_start, clk_out;

  int nvec = 0;
  int nfail = 0;
  logic exp_sw;

  always #2 clk = ~clk;

  clksync_top #(.TIMEOUT_TICKS(TO), .CNT_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sync_pin(sync_pin),
    .sw_clk(sw_clk), .ch1_start(ch1_start), .ch2_start(ch2_start),
    .clk_out(clk_out)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic t);
    osc_tick = t;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic pin);
    sync_pin = pin;
    rst_n = 1'b0;
    repeat (4) step(1'b0);
    chk("R1", "sw_clk in reset", sw_clk, 1'b0);
    chk("R1", "clk_out in reset", clk_out, 1'b0);
    chk("R1", "ch1_start in reset", ch1_start, 1'b0);
    chk("R1", "ch2_start in reset", ch2_start, 1'b0);
    rst_n = 1'b1;
    step(1'b0);
    chk("R1", "sw_clk after reset", sw_clk, 1'b0);
    chk("R1", "clk_out after reset", clk_out, 1'b0);
    exp_sw = 1'b0;
  endtask

  // Expect one toggle plus the matching strobe in this cycle.
  task automatic expect_tick(input string req);
    exp_sw = ~exp_sw;
    chk(req, "sw_clk toggled", sw_clk, exp_sw);
    chk("R3", "ch1_start at rise", ch1_start, exp_sw);
    chk("R4", "ch2_start at fall", ch2_start, ~exp_sw);
  endtask

  task automatic expect_idle(input string req);
    chk(req, "sw_clk held", sw_clk, exp_sw);
    chk(req, "ch1_start idle", ch1_start, 1'b0);
    chk(req, "ch2_start idle", ch2_start, 1'b0);
  endtask

  task automatic test_low();
    do_reset(1'b0);
    for (int i = 0; i < 6; i++) begin
      step(1'b1);
      expect_tick("R2");
      if (i == 0) chk("R1", "first strobe is ch1", ch1_start, 1'b1);
      chk("R5", "clk_out follows sw_clk", clk_out, exp_sw);
      for (int k = 1; k < 6; k++) begin
        step(1'b0);
        expect_idle("R2");
        chk("R5", "clk_out follows sw_clk", clk_out, exp_sw);
      end
    end
  endtask

  task automatic test_high(input int p);
    do_reset(1'b1);
    for (int i = 0; i < 6; i++) begin
      step(1'b1);
      expect_tick("R2");
      chk("R6", "clk_out low after tick", clk_out, 1'b0);
      for (int k = 1; k < p; k++) begin
        step(1'b0);
        expect_idle("R2");
        if (i >= 1) chk("R6", "quarter-shifted clk_out", clk_out, (k >= p / 2) ? 1'b1 : 1'b0);
      end
    end
  endtask

  // One sync pin period: 3 cycles high, 3 cycles low, with osc pulses mixed in.
  task automatic pin_period(input logic check);
    sync_pin = 1'b1;
    step(1'b1);
    if (check) expect_idle("R7");
    step(1'b0);
    if (check) expect_idle("R9");
    step(1'b0);
    if (check) begin
      expect_tick("R9");
      chk("R7", "clk_out follows sw_clk", clk_out, exp_sw);
    end
    sync_pin = 1'b0;
    step(1'b1);
    if (check) expect_idle("R7");
    step(1'b0);
    if (check) expect_idle("R7");
    step(1'b1);
    if (check) expect_idle("R7");
  endtask

  task automatic test_ext_and_timeout();
    do_reset(1'b0);
    pin_period(1'b0);
    pin_period(1'b0);
    exp_sw = sw_clk;
    for (int i = 0; i < 6; i++) pin_period(1'b1);
    repeat (3) step(1'b0);
    expect_idle("R8");
    for (int t = 0; t < TO; t++) begin
      step(1'b1);
      expect_idle("R8");
      repeat (5) step(1'b0);
    end
    step(1'b1);
    expect_tick("R8");
    chk("R5", "static low after timeout", clk_out, exp_sw);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nvec++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    test_low();
    test_high(8);
    test_high(7);
    test_ext_and_timeout();
    finish_run();
  end
endmodule